// File: doc/BRIEF.md
# CPU/Slave Shared-RAM Arbiter

This block lets two requesters share a single local RAM port. One is the processor core and the other is a bus slave interface. Each requester has its own request line, command fields (write enable, address, write data) and grant. The block decides which side owns the RAM in the current cycle. It steers that side's command onto the RAM port, and it returns the RAM read data to both sides.

Ownership is held in a register and changes only at a clock edge. The owner keeps the RAM for as long as it keeps requesting, until the other side has waited too long. Each side has its own programmable pending limit, measured in cycles. When the limit runs out, the current owner is forced to give up the RAM. When the processor wins the RAM, it gets a programmable tenure during which no arbitration takes place. A 16-bit control register holds both limits, the tenure and an enable for the slave side. While that enable is clear, slave requests stall indefinitely.

Top module: `ram_share_arb`

## Requirements
- R1: After reset the control register reads 16'h8411, both grants are low and the RAM enable is low.
- R2: The control register is loaded from `cfg_wdata_i` when `cfg_we_i` is high. Its fields are: slave pending limit in bits 15:11, processor pending limit in bits 10:6, processor tenure in bits 5:1, and slave enable in bit 0. The stored value reads back on `cfg_o`.
- R3: When the RAM is unowned, a requester is granted in the cycle after its request is seen. If both request in the same cycle, the processor is granted.
- R4: After the processor takes ownership in cycle g, it keeps the RAM through cycle g+tenure-1 whatever the slave does, even if the processor drops its request.
- R5: Suppose the processor took ownership in cycle g and the slave requests continuously from cycle s while the processor keeps requesting. Then the slave is first granted in cycle max(g+tenure, s+slave_limit)+1.
- R6: Suppose the slave owns the RAM and keeps requesting, and the processor requests continuously from cycle s. Then the processor is first granted in cycle s+cpu_limit+1.
- R7: An owner that keeps requesting while the other side is idle keeps its grant in every cycle.
- R8: While the slave enable is 0, `slv_gnt_o` stays low and the slave never drives the RAM. The processor is served normally.
- R9: At most one grant is high at a time. `ram_en_o` equals the OR of the grants. The granted side's write enable, address and write data appear on the RAM port. `ram_rdata_i` is returned on both read-data outputs.
- R10: If a waiting side drops its request, its wait count restarts, and its limit is measured from its next request.
- R11: A pending limit of 0 makes a waiting side preempt in the first cycle the owner is open to arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 16 | Control register write value |
| cfg_o | output | 16 | Control register contents |
| cpu_req_i | input | 1 | Processor request |
| cpu_we_i | input | 1 | Processor write enable |
| cpu_addr_i | input | AW | Processor address |
| cpu_wdata_i | input | DW | Processor write data |
| cpu_gnt_o | output | 1 | Processor grant |
| cpu_rdata_o | output | DW | Read data to processor |
| slv_req_i | input | 1 | Slave-interface request |
| slv_we_i | input | 1 | Slave-interface write enable |
| slv_addr_i | input | AW | Slave-interface address |
| slv_wdata_i | input | DW | Slave-interface write data |
| slv_gnt_o | output | 1 | Slave-interface grant |
| slv_rdata_o | output | DW | Read data to slave interface |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | AW | RAM address |
| ram_wdata_o | output | DW | RAM write data |
| ram_rdata_i | input | DW | RAM read data |

## Verification
The hardest case to reach is the point where a waiting slave's limit runs out close to the end of the processor's tenure. There the grant cycle is decided by whichever of the two bounds is later. To reach it, the stimulus draws random tenures, limits and slave start offsets. It then compares the first slave grant with max(g+tenure, s+limit)+1 computed in the bench. Directed cases cover three further situations: a processor that drops its request inside its tenure, a slave that stops and restarts its wait, and limits of zero.

// File: rtl/ram_arb_pkg.sv
package ram_arb_pkg;
  localparam int LIM_W = 5;
  localparam int CFG_W = 3 * LIM_W + 1;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_CPU  = 2'd1,
    OWN_SLV  = 2'd2
  } owner_e;

  // field order is the register bit layout, msb first
  typedef struct packed {
    logic [LIM_W-1:0] slv_lim;
    logic [LIM_W-1:0] cpu_lim;
    logic [LIM_W-1:0] cpu_hold;
    logic             slv_en;
  } arb_cfg_t;

  localparam arb_cfg_t CFG_RST = '{slv_lim: 5'd16, cpu_lim: 5'd16, cpu_hold: 5'd8, slv_en: 1'b1};
endpackage

// File: rtl/arb_cfg_reg.sv
module arb_cfg_reg
  import ram_arb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output arb_cfg_t         cfg_o
);
  arb_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= CFG_RST;
    else if (we_i) cfg_q <= arb_cfg_t'(wdata_i);
  end

  assign cfg_o = cfg_q;

  p_cfg_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> cfg_o == $past(wdata_i));
endmodule

// File: rtl/arb_wait_ctr.sv
module arb_wait_ctr #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic         served_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!req_i || served_i) cnt_q <= '0;
    else if (cnt_q != CNT_MAX)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_wait_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> cnt_o == '0);
  p_wait_sat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o == CNT_MAX && req_i && !served_i |=> cnt_o == CNT_MAX);
endmodule

// File: rtl/arb_owner_fsm.sv
module arb_owner_fsm
  import ram_arb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  arb_cfg_t         cfg_i,
  input  logic             cpu_req_i,
  input  logic             slv_req_i,   // already gated by enable
  input  logic [LIM_W-1:0] cpu_wait_i,
  input  logic [LIM_W-1:0] slv_wait_i,
  output owner_e           owner_o
);
  owner_e           owner_q, owner_d;
  logic [LIM_W-1:0] hold_q, hold_d;

  always_comb begin
    owner_d = owner_q;
    hold_d  = (hold_q != '0) ? hold_q - 1'b1 : '0;
    unique case (owner_q)
      OWN_NONE: begin
        if (cpu_req_i)      owner_d = OWN_CPU;
        else if (slv_req_i) owner_d = OWN_SLV;
      end
      OWN_CPU: begin
        // tenure window: no arbitration
        if (hold_q == '0) begin
          if (!cpu_req_i)
            owner_d = slv_req_i ? OWN_SLV : OWN_NONE;
          else if (slv_req_i && slv_wait_i >= cfg_i.slv_lim)
            owner_d = OWN_SLV;
        end
      end
      OWN_SLV: begin
        if (!slv_req_i)
          owner_d = cpu_req_i ? OWN_CPU : OWN_NONE;
        else if (cpu_req_i && cpu_wait_i >= cfg_i.cpu_lim)
          owner_d = OWN_CPU;
      end
      default: owner_d = OWN_NONE;
    endcase
    if (owner_d == OWN_CPU && owner_q != OWN_CPU) hold_d = cfg_i.cpu_hold;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= OWN_NONE;
      hold_q  <= '0;
    end else begin
      owner_q <= owner_d;
      hold_q  <= hold_d;
    end
  end

  assign owner_o = owner_q;

  p_tie_cpu_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_q == OWN_NONE && cpu_req_i |=> owner_q == OWN_CPU);
  p_tenure_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_q == OWN_CPU && hold_q != '0 |=> owner_q == OWN_CPU);
  p_slv_preempt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_q == OWN_CPU && hold_q == '0 && slv_req_i && slv_wait_i >= cfg_i.slv_lim
    |=> owner_q == OWN_SLV);
  p_cpu_preempt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_q == OWN_SLV && cpu_req_i && cpu_wait_i >= cfg_i.cpu_lim
    |=> owner_q == OWN_CPU && hold_q == $past(cfg_i.cpu_hold));
  p_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_q == OWN_CPU && cpu_req_i && !slv_req_i |=> owner_q == OWN_CPU);
endmodule

// File: rtl/arb_port_mux.sv
module arb_port_mux
  import ram_arb_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  owner_e        owner_i,
  input  logic          cpu_req_i,
  input  logic          slv_req_i,
  input  logic          slv_en_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  input  logic          slv_we_i,
  input  logic [AW-1:0] slv_addr_i,
  input  logic [DW-1:0] slv_wdata_i,
  output logic          cpu_gnt_o,
  output logic          slv_gnt_o,
  output logic          ram_en_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_wdata_o
);
  logic pick_slv;

  assign cpu_gnt_o   = (owner_i == OWN_CPU) && cpu_req_i;
  assign slv_gnt_o   = (owner_i == OWN_SLV) && slv_req_i && slv_en_i;
  assign pick_slv    = (owner_i == OWN_SLV);
  assign ram_en_o    = cpu_gnt_o || slv_gnt_o;
  assign ram_we_o    = ram_en_o && (pick_slv ? slv_we_i : cpu_we_i);
  assign ram_addr_o  = pick_slv ? slv_addr_i  : cpu_addr_i;
  assign ram_wdata_o = pick_slv ? slv_wdata_i : cpu_wdata_i;
endmodule

// File: rtl/ram_share_arb.sv
module ram_share_arb
  import ram_arb_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [15:0]   cfg_wdata_i,
  output logic [15:0]   cfg_o,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic          cpu_gnt_o,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic          slv_req_i,
  input  logic          slv_we_i,
  input  logic [AW-1:0] slv_addr_i,
  input  logic [DW-1:0] slv_wdata_i,
  output logic          slv_gnt_o,
  output logic [DW-1:0] slv_rdata_o,
  output logic          ram_en_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_wdata_o,
  input  logic [DW-1:0] ram_rdata_i
);
  localparam int N_SIDE = 2;  // 0: cpu, 1: slave

  arb_cfg_t         cfg;
  owner_e           owner;
  logic             slv_req_eff;
  logic [N_SIDE-1:0] w_req, w_served;
  logic [LIM_W-1:0] w_cnt [N_SIDE];

  arb_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  assign cfg_o       = cfg;
  assign slv_req_eff = slv_req_i && cfg.slv_en;

  assign w_req    = {slv_req_eff, cpu_req_i};
  assign w_served = {owner == OWN_SLV, owner == OWN_CPU};

  for (genvar i = 0; i < N_SIDE; i++) begin : g_wait
    arb_wait_ctr #(.W(LIM_W)) u_ctr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (w_req[i]),
      .served_i (w_served[i]),
      .cnt_o    (w_cnt[i])
    );
  end

  arb_owner_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_i      (cfg),
    .cpu_req_i  (cpu_req_i),
    .slv_req_i  (slv_req_eff),
    .cpu_wait_i (w_cnt[0]),
    .slv_wait_i (w_cnt[1]),
    .owner_o    (owner)
  );

  arb_port_mux #(.AW(AW), .DW(DW)) u_mux (
    .owner_i     (owner),
    .cpu_req_i   (cpu_req_i),
    .slv_req_i   (slv_req_i),
    .slv_en_i    (cfg.slv_en),
    .cpu_we_i    (cpu_we_i),
    .cpu_addr_i  (cpu_addr_i),
    .cpu_wdata_i (cpu_wdata_i),
    .slv_we_i    (slv_we_i),
    .slv_addr_i  (slv_addr_i),
    .slv_wdata_i (slv_wdata_i),
    .cpu_gnt_o   (cpu_gnt_o),
    .slv_gnt_o   (slv_gnt_o),
    .ram_en_o    (ram_en_o),
    .ram_we_o    (ram_we_o),
    .ram_addr_o  (ram_addr_o),
    .ram_wdata_o (ram_wdata_o)
  );

  assign cpu_rdata_o = ram_rdata_i;
  assign slv_rdata_o = ram_rdata_i;

  p_one_gnt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_gnt_o && slv_gnt_o));
  p_slv_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_o[0] |-> !slv_gnt_o);
  p_en_follow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_o == (cpu_gnt_o || slv_gnt_o));
endmodule

// File: tb/ram_share_arb_test.sv
module ram_share_arb_test;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [15:0]   cfg_wdata = '0;
  logic [15:0]   cfg_rd;
  logic          cpu_req = 1'b0, cpu_we = 1'b0, cpu_gnt;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
  logic          slv_req = 1'b0, slv_we = 1'b0, slv_gnt;
  logic [AW-1:0] slv_addr = '0;
  logic [DW-1:0] slv_wdata = '0, slv_rdata;
  logic          ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, ram_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ram_share_arb #(.AW(AW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_o(cfg_rd),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_gnt_o(cpu_gnt), .cpu_rdata_o(cpu_rdata),
    .slv_req_i(slv_req), .slv_we_i(slv_we), .slv_addr_i(slv_addr), .slv_wdata_i(slv_wdata),
    .slv_gnt_o(slv_gnt), .slv_rdata_o(slv_rdata),
    .ram_en_o(ram_en), .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata),
    .ram_rdata_i(ram_rdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R2 layout: [15:11] slave limit, [10:6] cpu limit, [5:1] tenure, [0] slave enable
  function automatic logic [15:0] mk_cfg(input int sl, input int cl, input int hd, input int en);
    return {sl[4:0], cl[4:0], hd[4:0], en[0]};
  endfunction

  function automatic int exp_slv(input int g, input int hd, input int s, input int lim);
    return ((g + hd > s + lim) ? g + hd : s + lim) + 1;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      cfg_we = 1'b0; cpu_req = 1'b0; slv_req = 1'b0;
    end
  endtask

  task automatic write_cfg(input logic [15:0] v);
    @(posedge clk); #1;
    cpu_req = 1'b0; slv_req = 1'b0;
    cfg_we = 1'b1; cfg_wdata = v;
  endtask

  // side A requests in cycles [0, a_len); side B from s, except in [b_off, b_on)
  task automatic trial(input bit cpu_first, input logic [15:0] cfgv, input int s,
                       input int a_len, input int b_off, input int b_on,
                       output int b_first, output int a_first, output int a_cnt,
                       output int gap, output int pt_err);
    bit a_req, b_req, a_g, b_g, ok;
    idle(40);
    write_cfg(cfgv);
    b_first = -1; a_first = -1; a_cnt = 0; gap = 0; pt_err = 0;
    for (int n = 0; n < 80; n++) begin
      @(posedge clk); #1;
      cfg_we = 1'b0;
      a_req = (n < a_len);
      b_req = (n >= s) && !(n >= b_off && n < b_on);
      cpu_req = cpu_first ? a_req : b_req;
      slv_req = cpu_first ? b_req : a_req;
      cpu_we = 1'($urandom); slv_we = 1'($urandom);
      cpu_addr = AW'($urandom); slv_addr = AW'($urandom);
      cpu_wdata = $urandom; slv_wdata = $urandom; ram_rdata = $urandom;
      @(negedge clk);
      ok = (ram_en == (cpu_gnt || slv_gnt)) && !(cpu_gnt && slv_gnt)
           && cpu_rdata == ram_rdata && slv_rdata == ram_rdata;
      if (cpu_gnt) ok = ok && ram_addr == cpu_addr && ram_wdata == cpu_wdata && ram_we == cpu_we;
      if (slv_gnt) ok = ok && ram_addr == slv_addr && ram_wdata == slv_wdata && ram_we == slv_we;
      if (!ok) pt_err++;
      a_g = cpu_first ? cpu_gnt : slv_gnt;
      b_g = cpu_first ? slv_gnt : cpu_gnt;
      if (a_g) a_cnt++;
      if (a_g && a_first < 0) a_first = n;
      if (b_first < 0 && b_g) b_first = n;
      if (b_first < 0 && n >= 1 && a_req && !a_g) gap++;
    end
    idle(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int bf, af, ac, gp, pe, lim, hd, s, e;
    process::self().srandom(32'd1357);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(cfg_rd == 16'h8411, "R1 cfg reset", cfg_rd, 16'h8411);
    check(!cpu_gnt && !slv_gnt, "R1 grants low", {cpu_gnt, slv_gnt}, 0);
    check(!ram_en, "R1 ram idle", ram_en, 0);
    rst_n = 1'b1;

    // R2 write and readback
    write_cfg(mk_cfg(3, 7, 2, 1));
    idle(1);
    @(negedge clk);
    check(cfg_rd == 16'h19C5, "R2 readback", cfg_rd, 16'h19C5);

    // R3 slave alone from idle
    trial(1'b0, mk_cfg(16, 16, 8, 1), 1000, 1000, 0, 0, bf, af, ac, gp, pe);
    check(af == 1, "R3 lone slave grant cycle", af, 1);
    // R3 tie, R11 limit 0 with tenure 3: slave at max(1+3,0+0)+1
    trial(1'b1, mk_cfg(0, 16, 3, 1), 0, 1000, 0, 0, bf, af, ac, gp, pe);
    check(af == 1, "R3 tie cpu first", af, 1);
    check(bf == 5, "R11 zero limit after tenure", bf, 5);
    check(pe == 0, "R9 passthrough tie", pe, 0);

    // R7 cpu keeps RAM with no competitor
    trial(1'b1, mk_cfg(0, 0, 0, 1), 1000, 1000, 0, 0, bf, af, ac, gp, pe);
    check(ac == 79 && gp == 0, "R7 cpu held", ac, 79);
    // R7 slave keeps RAM with no competitor
    trial(1'b0, mk_cfg(0, 0, 0, 1), 1000, 1000, 0, 0, bf, af, ac, gp, pe);
    check(ac == 79 && gp == 0, "R7 slave held", ac, 79);

    // R4 cpu drops inside tenure; slave waits for window end: 12
    trial(1'b1, mk_cfg(0, 16, 10, 1), 1, 1, 0, 0, bf, af, ac, gp, pe);
    check(bf == 12, "R4 tenure kept after drop", bf, 12);

    // R10 slave drops at 6, restarts at 8, limit 6: grant 15
    trial(1'b1, mk_cfg(6, 16, 0, 1), 2, 1000, 6, 8, bf, af, ac, gp, pe);
    check(bf == 15, "R10 wait restart", bf, 15);

    // R8 slave disabled: never granted, cpu from 10 served at 11
    trial(1'b0, mk_cfg(0, 0, 0, 0), 10, 1000, 0, 0, bf, af, ac, gp, pe);
    check(ac == 0, "R8 slave stalled", ac, 0);
    check(bf == 11, "R8 cpu served", bf, 11);
    check(pe == 0, "R8 ram untouched by slave", pe, 0);
    // R8 re-enabled: slave served again
    trial(1'b0, mk_cfg(16, 16, 8, 1), 1000, 1000, 0, 0, bf, af, ac, gp, pe);
    check(af == 1, "R8 slave after enable", af, 1);

    // R5 / R6 / R9 random
    for (int t = 0; t < 40; t++) begin
      lim = $urandom_range(0, 20); hd = $urandom_range(0, 12); s = $urandom_range(1, 10);
      trial(1'b1, mk_cfg(lim, 16, hd, 1), s, 1000, 0, 0, bf, af, ac, gp, pe);
      e = exp_slv(1, hd, s, lim);
      check(bf == e, "R5 slave preempt cycle", bf, e);
      check(gp == 0, "R4 cpu kept until preempt", gp, 0);
      check(pe == 0, "R9 passthrough", pe, 0);
    end
    for (int t = 0; t < 40; t++) begin
      lim = $urandom_range(0, 20); hd = $urandom_range(0, 12); s = $urandom_range(1, 10);
      trial(1'b0, mk_cfg(16, lim, hd, 1), s, 1000, 0, 0, bf, af, ac, gp, pe);
      e = s + lim + 1;
      check(bf == e, "R6 cpu preempt cycle", bf, e);
      check(gp == 0, "R7 slave kept until preempt", gp, 0);
      check(pe == 0, "R9 passthrough", pe, 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule